// File: doc/BRIEF.md
# Priority Arbiter for Shared-Memory DMA Clients

This block decides which of three DMA clients gets the next turn at a shared memory. The clients are a video I/O port, a processor data-memory port and a host-interface buffer port. Each client raises a request line. The arbiter answers with a one-hot grant that stays asserted until the owning client pulses `xfer_done`. The block does not handle memory timing, address generation or data movement.

Priority runs on a four-step scale. Step 0 is the most urgent and step 3 the least urgent. The video port always competes at step 0 because its transfers recur on a fixed period and cannot wait. The processor and host ports each hold a 2-bit urgency that is written through a small register port. Software can give them step 1, 2 or 3, but never step 0. When both hold the same step, a rotating pointer decides between them.

The request/grant pair works as a valid/ready handshake. A client holds its request until it sees its grant bit. The grant stays high, acting as back-pressure on every other client, until the owner signals done.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset the grant is all zero. Both programmable urgencies are step 3. The tie pointer favours the processor port.
- R2: `gnt` is zero or one-hot. Bit 0 is the video port, bit 1 the processor port and bit 2 the host port.
- R3: At any clock edge where no grant is held and at least one request is high, a grant to a requesting client is registered at that edge.
- R4: At such an edge a video request wins, whatever the other requests and urgencies are.
- R5: Without a video request, the processor or host request with the numerically smaller urgency wins.
- R6: A write with `cfg_we` high sets the urgency of the port chosen by `cfg_sel` (0 = processor, 1 = host) to `cfg_level`. The new value is used from the next clock edge onward.
- R7: Writing urgency 0 to a programmable port stores step 1.
- R8: When processor and host have equal urgency, the pointer picks between them. After each grant to one of these two ports, the pointer turns to favour the other.
- R9: A held grant does not change while `xfer_done` is low. `xfer_done` high at an edge clears the grant. Arbitration then takes place at the following edge.
- R10: With no request pending at an arbitration edge, no grant is raised.
- R11: `xfer_done` asserted while no grant is held has no effect. Arbitration at that edge proceeds as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Urgency register write strobe |
| cfg_sel | input | 1 | Target port of the write: 0 processor, 1 host |
| cfg_level | input | 2 | Urgency step to write |
| vid_req | input | 1 | Video port request |
| proc_req | input | 1 | Processor data-memory port request |
| host_req | input | 1 | Host buffer port request |
| xfer_done | input | 1 | Owner signals that its transfer is finished |
| gnt | output | 3 | One-hot grant: bit 0 video, bit 1 processor, bit 2 host |

## Verification
The assertions assume that all inputs are known 2-state values after reset. They also assume that `xfer_done` has meaning only while a grant is held. Done pulses that arrive at other times must be harmless, and one property checks this. The stimulus holds a fixed seed. It includes done pulses on idle cycles, configuration writes of every value including the reserved step 0, and requests that drop and rise freely. This keeps the run inside the legal input space while still reaching the corner cases.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int LVL_W     = 2;
  localparam int NSW       = 2;
  localparam int NCLI      = NSW + 1;
  localparam int SEL_W     = (NSW > 1) ? $clog2(NSW) : 1;
  localparam int IDX_VID   = 0;
  localparam int IDX_PROC  = 1;
  localparam int IDX_HOST  = 2;
  localparam logic [LVL_W-1:0] LVL_FLOOR = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_RESET = {LVL_W{1'b1}};
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [NCLI-1:0]  gnt_t;
endpackage

// File: rtl/prio_regs.sv
module prio_regs
  import dma_arb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [SEL_W-1:0]          sel,
  input  lvl_t                      wlevel,
  output logic [NSW-1:0][LVL_W-1:0] lvl
);
  lvl_t wclamped;
  assign wclamped = (wlevel == '0) ? LVL_FLOOR : wlevel;

  for (genvar i = 0; i < NSW; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl[i] <= LVL_RESET;
      else if (we && (sel == SEL_W'(i)))
        lvl[i] <= wclamped;
    end

    assert_level_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[i] != '0);
  end
endmodule

// File: rtl/prio_select.sv
module prio_select
  import dma_arb_pkg::*;
(
  input  logic                      vid_req,
  input  logic [NSW-1:0]            sw_req,
  input  logic [NSW-1:0][LVL_W-1:0] lvl,
  input  logic                      rr_host,
  output gnt_t                      pick
);
  logic proc_wins;

  always_comb begin
    if (lvl[0] < lvl[1])      proc_wins = 1'b1;
    else if (lvl[1] < lvl[0]) proc_wins = 1'b0;
    else                      proc_wins = !rr_host;
  end

  always_comb begin
    pick = '0;
    if (vid_req)
      pick[IDX_VID] = 1'b1;
    else if (sw_req[0] && sw_req[1])
      pick[proc_wins ? IDX_PROC : IDX_HOST] = 1'b1;
    else if (sw_req[0])
      pick[IDX_PROC] = 1'b1;
    else if (sw_req[1])
      pick[IDX_HOST] = 1'b1;
  end
endmodule

// File: rtl/grant_ctrl.sv
module grant_ctrl
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  gnt_t pick,
  input  logic done,
  output gnt_t gnt,
  output logic rr_host
);
  logic idle;
  assign idle = (gnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt     <= '0;
      rr_host <= 1'b0;
    end else if (idle) begin
      gnt <= pick;
      if (pick[IDX_PROC]) rr_host <= 1'b1;
      if (pick[IDX_HOST]) rr_host <= 1'b0;
    end else if (done) begin
      gnt <= '0;
    end
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !done) |=> $stable(gnt));
  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && done) |=> (gnt == '0));
  assert_ptr_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pick[IDX_PROC]) |=> rr_host);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             vid_req,
  input  logic             proc_req,
  input  logic             host_req,
  input  logic             xfer_done,
  output logic [NCLI-1:0]  gnt
);
  logic [NSW-1:0][LVL_W-1:0] lvl;
  logic [NSW-1:0]            sw_req;
  gnt_t                      pick;
  logic                      rr_host;

  assign sw_req = {host_req, proc_req};

  prio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(SEL_W'(cfg_sel)),
    .wlevel(cfg_level), .lvl(lvl)
  );

  prio_select u_sel (
    .vid_req(vid_req), .sw_req(sw_req), .lvl(lvl),
    .rr_host(rr_host), .pick(pick)
  );

  grant_ctrl u_gnt (
    .clk(clk), .rst_n(rst_n), .pick(pick), .done(xfer_done),
    .gnt(gnt), .rr_host(rr_host)
  );

  assert_video_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && vid_req) |=> gnt[IDX_VID]);
  assert_no_req_no_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && !vid_req && !proc_req && !host_req) |=> (gnt == '0));
  assert_arbitrate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && (vid_req || proc_req || host_req)) |=> (gnt != '0));
  assert_idle_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0 && xfer_done && proc_req && !vid_req && !host_req) |=> gnt[IDX_PROC]);
endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [1:0] cfg_level = 2'd0;
  logic vid_req = 1'b0, proc_req = 1'b0, host_req = 1'b0, xfer_done = 1'b0;
  logic [2:0] gnt;

  int n_chk = 0, n_bad = 0;
  logic [2:0] m_gnt;
  logic [1:0] m_lp, m_lh;
  logic       m_ptr;

  always #10 clk = ~clk;

  dma_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_level(cfg_level), .vid_req(vid_req), .proc_req(proc_req),
    .host_req(host_req), .xfer_done(xfer_done), .gnt(gnt)
  );

  function automatic logic [2:0] ref_pick(logic v, logic p, logic h,
                                          logic [1:0] lp, logic [1:0] lh, logic ptr);
    if (v) return 3'b001;
    if (p && h) begin
      if (lp < lh) return 3'b010;
      if (lh < lp) return 3'b100;
      return ptr ? 3'b100 : 3'b010;
    end
    if (p) return 3'b010;
    if (h) return 3'b100;
    return 3'b000;
  endfunction

  task automatic check(string tag, logic [2:0] exp);
    n_chk++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt actual=%b expected=%b", tag, gnt, exp);
    end
  endtask

  task automatic step(logic v, logic p, logic h, logic d,
                      logic we, logic sel, logic [1:0] lv, string tag);
    logic [2:0] pk;
    vid_req = v; proc_req = p; host_req = h; xfer_done = d;
    cfg_we = we; cfg_sel = sel; cfg_level = lv;
    if (m_gnt == 3'b000) begin
      pk = ref_pick(v, p, h, m_lp, m_lh, m_ptr);
      m_gnt = pk;
      if (pk[1]) m_ptr = 1'b1;
      if (pk[2]) m_ptr = 1'b0;
    end else if (d) begin
      m_gnt = 3'b000;
    end
    if (we) begin
      if (sel) m_lh = (lv == 2'd0) ? 2'd1 : lv;
      else     m_lp = (lv == 2'd0) ? 2'd1 : lv;
    end
    @(negedge clk);
    check(tag, m_gnt);
    if (!$onehot0(gnt)) begin
      n_chk++; n_bad++;
      $display("FAIL R2: gnt actual=%b expected=one-hot or zero", gnt);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_gnt = 3'b000; m_lp = 2'd3; m_lh = 2'd3; m_ptr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 3'b000);

    step(0,1,1,0, 0,0,2'd0, "R1 tie favours processor");
    step(0,1,1,0, 0,0,2'd0, "R9 hold");
    step(1,1,1,0, 0,0,2'd0, "R9 hold against video");
    step(0,1,1,1, 0,0,2'd0, "R9 release");
    step(0,1,1,0, 0,0,2'd0, "R8 pointer turns to host");
    step(0,0,0,1, 0,0,2'd0, "R9 release host");
    step(0,0,0,0, 1,0,2'd0, "R10 idle during write");
    step(0,0,0,0, 1,1,2'd2, "R6 write host");
    step(0,1,1,0, 0,0,2'd0, "R5 processor level 1 beats 2");
    step(0,1,1,1, 1,1,2'd0, "R7 write 0 to host");
    step(0,1,1,0, 0,0,2'd0, "R7 clamped tie goes to host");
    step(0,0,0,1, 0,0,2'd0, "R9 release");
    step(1,1,1,0, 0,0,2'd0, "R4 video first");
    step(0,0,0,1, 0,0,2'd0, "R9 release video");
    step(0,1,0,1, 0,0,2'd0, "R11 done ignored when idle");
    step(0,0,0,1, 0,0,2'd0, "R9 release");
    step(0,0,1,0, 0,0,2'd0, "R3 single request");

    void'($urandom(32'd2718));
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0,3) == 0, $urandom_range(0,1) == 1,
           $urandom_range(0,1) == 1, $urandom_range(0,2) == 0,
           $urandom_range(0,9) == 0, 1'($urandom_range(0,1)),
           2'($urandom_range(0,3)), "R3 R5 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule